// File: doc/BRIEF.md
# Branch Condition and Next-Index Resolver

This block resolves control flow for the two jump instruction classes of a small packet-filter virtual machine. It takes the decoded fields of one instruction: opcode, source-register field, 16-bit offset and 32-bit immediate. It also takes the two register operands and the index of the current instruction. From these it produces the index of the next instruction to run and a taken flag. It also raises one of four indications: helper call, program-local call, return, or illegal jump encoding. The call stack, helper dispatch and instruction fetch belong to the surrounding engine.

The opcode is split into three fields. Bits 7:4 hold the operation code. Bit 3 selects the second operand: 1 takes the source register, 0 takes the immediate. Bits 2:0 hold the class. Class 5 compares the whole 64-bit operands and class 6 compares only their low 32 bits. All other classes are treated as straight-line code. The result is computed combinationally and then held in one output register stage, so the answer for an instruction appears on the outputs one clock after its fields are presented.

Top module: `branch_resolver`

## Requirements
- R1: While `rst_n` is low, and after it, until the first clock edge with `rst_n` high, `next_idx` is 0 and `taken`, `helper_call`, `local_call`, `ret` and `illegal` are all 0.
- R2: The outputs reflect the inputs sampled at the previous rising clock edge. Changing the inputs between edges leaves the outputs unchanged.
- R3: An opcode whose class (bits 2:0) is neither 5 nor 6 gives `next_idx` = `cur_idx` + 1, or `cur_idx` + 2 when `wide_insn` is 1, wrapping modulo 2^IDX_W. `taken` and all four indications are 0.
- R4: Class 5 compares `dst_val` and the second operand over all 64 bits. Class 6 compares bits 31:0 only, so differences in bits 63:32 do not affect the outcome, and the sign for signed compares is bit 31.
- R5: With opcode bit 3 at 0, the second operand is the immediate sign-extended to 64 bits. With bit 3 at 1, it is `src_val`.
- R6: The conditional operation codes (bits 7:4) are as follows. 0x1 equal, 0x5 not equal, 0x4 nonzero bitwise AND. Unsigned: 0x2 greater, 0x3 greater-or-equal, 0xa less, 0xb less-or-equal. Signed: 0x6 greater, 0x7 greater-or-equal, 0xc less, 0xd less-or-equal.
- R7: A taken conditional branch gives `next_idx` = `cur_idx` + 1 + sign-extended `offset`, and `wide_insn` is ignored. A branch that is not taken falls through as in R3.
- R8: Operation code 0x0 is always taken. In class 5 it jumps by the sign-extended `offset`, and in class 6 by the sign-extended `imm`, both relative to `cur_idx` + 1.
- R9: Operation code 0x8 with bit 3 at 0 is a call. A source field of 0 or 2 raises `helper_call`, with `taken` 0 and fall-through `next_idx`. A source field of 1 raises `local_call`, with `taken` 1 and `next_idx` = `cur_idx` + 1 + sign-extended `imm`.
- R10: Operation code 0x9 with bit 3 at 0 raises `ret`, with `taken` 0 and fall-through `next_idx`.
- R11: In classes 5 and 6, `illegal` is raised with `taken` 0 and fall-through `next_idx` in these cases: operation codes 0xe and 0xf, codes 0x8 or 0x9 with bit 3 set, and code 0x8 with a source field above 2.
- R12: At most one of `helper_call`, `local_call`, `ret` and `illegal` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | 8 | Operation code, operand select and class |
| sreg_field | input | 4 | Source-register field, used as call kind |
| offset | input | 16 | Signed branch displacement |
| imm | input | 32 | Signed immediate: operand or displacement |
| dst_val | input | 64 | First comparison operand |
| src_val | input | 64 | Register form of the second operand |
| cur_idx | input | IDX_W | Index of the current instruction |
| wide_insn | input | 1 | Current instruction occupies two slots |
| next_idx | output | IDX_W | Index of the next instruction |
| taken | output | 1 | Control transfers away from fall-through |
| helper_call | output | 1 | Call to a helper by ID |
| local_call | output | 1 | Call to a function within the program |
| ret | output | 1 | Return from the current function |
| illegal | output | 1 | Unsupported jump-class encoding |

## Verification
The bench builds the block with its defaults: 64-bit operands and a 32-bit instruction index. The 64-bit width makes it possible to choose operands that agree in their low word but differ above it, so the two compare classes must disagree. The 32-bit index lets backward displacements and the wrap from the top index to zero be checked exactly.

// File: rtl/br_pkg.sv
package br_pkg;

    localparam logic [2:0] CLS_WIDE   = 3'd5;
    localparam logic [2:0] CLS_NARROW = 3'd6;

    localparam logic [3:0] OP_JUMP   = 4'h0;
    localparam logic [3:0] OP_EQ     = 4'h1;
    localparam logic [3:0] OP_UGT    = 4'h2;
    localparam logic [3:0] OP_UGE    = 4'h3;
    localparam logic [3:0] OP_BITS   = 4'h4;
    localparam logic [3:0] OP_NE     = 4'h5;
    localparam logic [3:0] OP_SGT    = 4'h6;
    localparam logic [3:0] OP_SGE    = 4'h7;
    localparam logic [3:0] OP_CALL   = 4'h8;
    localparam logic [3:0] OP_RETURN = 4'h9;
    localparam logic [3:0] OP_ULT    = 4'ha;
    localparam logic [3:0] OP_ULE    = 4'hb;
    localparam logic [3:0] OP_SLT    = 4'hc;
    localparam logic [3:0] OP_SLE    = 4'hd;

    typedef enum logic [2:0] {
        KIND_SEQ,
        KIND_JUMP,
        KIND_COND,
        KIND_HELPER,
        KIND_LOCAL,
        KIND_RETURN,
        KIND_BAD
    } kind_e;

    typedef struct packed {
        logic eq;
        logic ult;
        logic slt;
        logic any;
    } cmp_flags_t;

endpackage

// File: rtl/br_decode.sv
module br_decode
    import br_pkg::*;
(
    input  logic [7:0] opcode,
    input  logic [3:0] sreg_field,
    output kind_e      kind,
    output logic       narrow,
    output logic       use_reg
);
    logic [2:0] cls;
    logic [3:0] op;

    always_comb begin
        cls     = opcode[2:0];
        op      = opcode[7:4];
        use_reg = opcode[3];
        narrow  = (cls == CLS_NARROW);
        kind    = KIND_SEQ;
        if (cls == CLS_WIDE || cls == CLS_NARROW) begin
            unique case (op)
                OP_JUMP: kind = KIND_JUMP;
                OP_EQ, OP_UGT, OP_UGE, OP_BITS, OP_NE, OP_SGT, OP_SGE,
                OP_ULT, OP_ULE, OP_SLT, OP_SLE: kind = KIND_COND;
                OP_CALL: begin
                    if (use_reg) begin
                        kind = KIND_BAD;
                    end else begin
                        unique case (sreg_field)
                            4'd0, 4'd2: kind = KIND_HELPER;
                            4'd1:       kind = KIND_LOCAL;
                            default:    kind = KIND_BAD;
                        endcase
                    end
                end
                OP_RETURN: kind = use_reg ? KIND_BAD : KIND_RETURN;
                default:   kind = KIND_BAD;
            endcase
        end
    end
endmodule

// File: rtl/br_cmp.sv
module br_cmp
    import br_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output cmp_flags_t   flags
);
    always_comb begin
        flags.eq  = (a == b);
        flags.ult = (a < b);
        flags.slt = ($signed(a) < $signed(b));
        flags.any = |(a & b);
    end
endmodule

// File: rtl/br_target.sv
module br_target #(
    parameter int IDX_W = 32
) (
    input  logic [IDX_W-1:0] cur_idx,
    input  logic [IDX_W-1:0] disp,
    input  logic             wide_insn,
    output logic [IDX_W-1:0] jump_idx,
    output logic [IDX_W-1:0] fall_idx
);
    logic [IDX_W-1:0] after_idx;

    always_comb begin
        after_idx = cur_idx + IDX_W'(1);
        jump_idx  = after_idx + disp;
        fall_idx  = wide_insn ? (after_idx + IDX_W'(1)) : after_idx;
    end
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
    import br_pkg::*;
#(
    parameter int IDX_W  = 32,
    parameter int DATA_W = 64,
    parameter int OFF_W  = 16,
    parameter int IMM_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        opcode,
    input  logic [3:0]        sreg_field,
    input  logic [OFF_W-1:0]  offset,
    input  logic [IMM_W-1:0]  imm,
    input  logic [DATA_W-1:0] dst_val,
    input  logic [DATA_W-1:0] src_val,
    input  logic [IDX_W-1:0]  cur_idx,
    input  logic              wide_insn,
    output logic [IDX_W-1:0]  next_idx,
    output logic              taken,
    output logic              helper_call,
    output logic              local_call,
    output logic              ret,
    output logic              illegal
);
    localparam int NARROW_W = DATA_W / 2;

    typedef struct packed {
        logic [IDX_W-1:0] next_idx;
        logic             taken;
        logic             helper_call;
        logic             local_call;
        logic             ret;
        logic             illegal;
    } res_t;

    kind_e             kind;
    logic              narrow;
    logic              use_reg;
    logic [DATA_W-1:0] operand_b;
    logic [IDX_W-1:0]  off_ext;
    logic [IDX_W-1:0]  imm_ext;
    logic [IDX_W-1:0]  disp;
    logic [IDX_W-1:0]  jump_idx;
    logic [IDX_W-1:0]  fall_idx;
    cmp_flags_t        flags_full;
    cmp_flags_t        flags_low;
    cmp_flags_t        flags;
    logic              hit;
    res_t              res_d;
    res_t              res_q;

    br_decode i_decode (
        .opcode     (opcode),
        .sreg_field (sreg_field),
        .kind       (kind),
        .narrow     (narrow),
        .use_reg    (use_reg)
    );

    always_comb begin
        operand_b = use_reg ? src_val : DATA_W'($signed(imm));
        off_ext   = IDX_W'($signed(offset));
        imm_ext   = IDX_W'($signed(imm));
        if ((kind == KIND_JUMP && narrow) || kind == KIND_LOCAL) begin
            disp = imm_ext;
        end else begin
            disp = off_ext;
        end
    end

    br_cmp #(.W(DATA_W)) i_cmp_full (
        .a     (dst_val),
        .b     (operand_b),
        .flags (flags_full)
    );

    br_cmp #(.W(NARROW_W)) i_cmp_low (
        .a     (dst_val[NARROW_W-1:0]),
        .b     (operand_b[NARROW_W-1:0]),
        .flags (flags_low)
    );

    br_target #(.IDX_W(IDX_W)) i_target (
        .cur_idx   (cur_idx),
        .disp      (disp),
        .wide_insn (wide_insn),
        .jump_idx  (jump_idx),
        .fall_idx  (fall_idx)
    );

    always_comb begin
        flags = narrow ? flags_low : flags_full;
        unique case (opcode[7:4])
            OP_EQ:   hit = flags.eq;
            OP_NE:   hit = !flags.eq;
            OP_BITS: hit = flags.any;
            OP_UGT:  hit = !flags.ult && !flags.eq;
            OP_UGE:  hit = !flags.ult;
            OP_ULT:  hit = flags.ult;
            OP_ULE:  hit = flags.ult || flags.eq;
            OP_SGT:  hit = !flags.slt && !flags.eq;
            OP_SGE:  hit = !flags.slt;
            OP_SLT:  hit = flags.slt;
            OP_SLE:  hit = flags.slt || flags.eq;
            default: hit = 1'b0;
        endcase
    end

    always_comb begin
        res_d          = '0;
        res_d.next_idx = fall_idx;
        unique case (kind)
            KIND_JUMP: begin
                res_d.taken    = 1'b1;
                res_d.next_idx = jump_idx;
            end
            KIND_COND: begin
                res_d.taken    = hit;
                res_d.next_idx = hit ? jump_idx : fall_idx;
            end
            KIND_HELPER: res_d.helper_call = 1'b1;
            KIND_LOCAL: begin
                res_d.local_call = 1'b1;
                res_d.taken      = 1'b1;
                res_d.next_idx   = jump_idx;
            end
            KIND_RETURN: res_d.ret     = 1'b1;
            KIND_BAD:    res_d.illegal = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign next_idx    = res_q.next_idx;
    assign taken       = res_q.taken;
    assign helper_call = res_q.helper_call;
    assign local_call  = res_q.local_call;
    assign ret         = res_q.ret;
    assign illegal     = res_q.illegal;

endmodule

// File: rtl/branch_resolver_chk.sv
module branch_resolver_chk #(
    parameter int IDX_W  = 32,
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        opcode,
    input logic [DATA_W-1:0] dst_val,
    input logic [DATA_W-1:0] src_val,
    input logic [IDX_W-1:0]  cur_idx,
    input logic              wide_insn,
    input logic [IDX_W-1:0]  next_idx,
    input logic              taken,
    input logic              helper_call,
    input logic              local_call,
    input logic              ret,
    input logic              illegal
);
    AST_ONE_INDICATION: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({helper_call, local_call, ret, illegal})); // R12

    AST_BAD_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !taken); // R11

    AST_HELPER_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        helper_call |-> !taken); // R9

    AST_LOCAL_JUMPS: assert property (@(posedge clk) disable iff (!rst_n)
        local_call |-> taken); // R9

    AST_RETURN_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        ret |-> !taken); // R10

    AST_STRAIGHT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode[2:0] != 3'd5 && opcode[2:0] != 3'd6) |=>
        (!taken && next_idx == $past(cur_idx) + ($past(wide_insn) ? IDX_W'(2) : IDX_W'(1)))); // R3

    AST_FULL_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 8'h1d && dst_val == src_val) |=> taken); // R6

    AST_LOW_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 8'h1e && dst_val[31:0] == src_val[31:0]) |=> taken); // R4
endmodule

bind branch_resolver branch_resolver_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .opcode      (opcode),
    .dst_val     (dst_val),
    .src_val     (src_val),
    .cur_idx     (cur_idx),
    .wide_insn   (wide_insn),
    .next_idx    (next_idx),
    .taken       (taken),
    .helper_call (helper_call),
    .local_call  (local_call),
    .ret         (ret),
    .illegal     (illegal)
);

// File: tb/test_branch_resolver.sv
`timescale 1ns/1ps
module test_branch_resolver;
    localparam int IDX_W = 32;

    typedef struct packed {
        logic [7:0]       req;
        logic [7:0]       opcode;
        logic [3:0]       sreg;
        logic [15:0]      off;
        logic [31:0]      imm;
        logic [63:0]      dst;
        logic [63:0]      src;
        logic [31:0]      idx;
        logic             wide;
        logic [31:0]      exp_idx;
        logic             exp_taken;
        logic [3:0]       exp_flags;   // {helper, local, ret, illegal}
    } vec_t;

    localparam int NV = 37;
    localparam vec_t VECS [NV] = '{
        '{8'd3,  8'h07, 4'h0, 16'h0000, 32'h0,        64'h0,                  64'h0,                  32'd100,        1'b0, 32'd101,  1'b0, 4'b0000}, // R3
        '{8'd3,  8'h18, 4'h0, 16'h0000, 32'h0,        64'h0,                  64'h0,                  32'd100,        1'b1, 32'd102,  1'b0, 4'b0000}, // R3
        '{8'd3,  8'h04, 4'h0, 16'h0005, 32'h0,        64'h0,                  64'h0,                  32'hFFFF_FFFF,  1'b0, 32'd0,    1'b0, 4'b0000}, // R3 wrap
        '{8'd6,  8'h1d, 4'h0, 16'h0005, 32'h0,        64'h1234_5678_9abc_def0, 64'h1234_5678_9abc_def0, 32'd100,       1'b0, 32'd106,  1'b1, 4'b0000}, // R6
        '{8'd4,  8'h1d, 4'h0, 16'h0005, 32'h0,        64'h1_0000_0005,        64'h5,                  32'd100,        1'b0, 32'd101,  1'b0, 4'b0000}, // R4
        '{8'd4,  8'h1e, 4'h0, 16'h0005, 32'h0,        64'h1_0000_0005,        64'h5,                  32'd100,        1'b0, 32'd106,  1'b1, 4'b0000}, // R4
        '{8'd6,  8'h2d, 4'h0, 16'hFFFE, 32'h0,        64'hFFFF_FFFF_FFFF_FFFF, 64'h1,                 32'd100,        1'b0, 32'd99,   1'b1, 4'b0000}, // R6
        '{8'd6,  8'h6d, 4'h0, 16'hFFFE, 32'h0,        64'hFFFF_FFFF_FFFF_FFFF, 64'h1,                 32'd100,        1'b0, 32'd101,  1'b0, 4'b0000}, // R6
        '{8'd6,  8'hcd, 4'h0, 16'h0005, 32'h0,        64'hFFFF_FFFF_FFFF_FFFF, 64'h1,                 32'd100,        1'b0, 32'd106,  1'b1, 4'b0000}, // R6
        '{8'd6,  8'h3d, 4'h0, 16'h0005, 32'h0,        64'h7,                  64'h7,                  32'd100,        1'b0, 32'd106,  1'b1, 4'b0000}, // R6
        '{8'd6,  8'had, 4'h0, 16'h0005, 32'h0,        64'h3,                  64'h7,                  32'd100,        1'b0, 32'd106,  1'b1, 4'b0000}, // R6
        '{8'd6,  8'hbd, 4'h0, 16'h0005, 32'h0,        64'h7,                  64'h7,                  32'd100,        1'b0, 32'd106,  1'b1, 4'b0000}, // R6
        '{8'd6,  8'h7d, 4'h0, 16'h0005, 32'h0,        64'hFFFF_FFFF_FFFF_FFFB, 64'hFFFF_FFFF_FFFF_FFFB, 32'd100,       1'b0, 32'd106,  1'b1, 4'b0000}, // R6
        '{8'd6,  8'hdd, 4'h0, 16'h0005, 32'h0,        64'hFFFF_FFFF_FFFF_FFFA, 64'hFFFF_FFFF_FFFF_FFFB, 32'd100,       1'b0, 32'd106,  1'b1, 4'b0000}, // R6
        '{8'd6,  8'h4d, 4'h0, 16'h0005, 32'h0,        64'hF0,                 64'h0F,                 32'd100,        1'b0, 32'd101,  1'b0, 4'b0000}, // R6
        '{8'd6,  8'h4d, 4'h0, 16'h0005, 32'h0,        64'hF0,                 64'h10,                 32'd100,        1'b0, 32'd106,  1'b1, 4'b0000}, // R6
        '{8'd6,  8'h5d, 4'h0, 16'h0005, 32'h0,        64'h1,                  64'h2,                  32'd100,        1'b0, 32'd106,  1'b1, 4'b0000}, // R6
        '{8'd6,  8'hbd, 4'h0, 16'h0005, 32'h0,        64'h8,                  64'h7,                  32'd100,        1'b0, 32'd101,  1'b0, 4'b0000}, // R6
        '{8'd5,  8'h15, 4'h0, 16'h0005, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0,                32'd100,        1'b0, 32'd106,  1'b1, 4'b0000}, // R5
        '{8'd5,  8'h15, 4'h0, 16'h0005, 32'hFFFF_FFFF, 64'h0000_0000_FFFF_FFFF, 64'h0,                32'd100,        1'b0, 32'd101,  1'b0, 4'b0000}, // R5
        '{8'd4,  8'h66, 4'h0, 16'h0005, 32'h1,        64'h8000_0000,          64'h0,                  32'd100,        1'b0, 32'd101,  1'b0, 4'b0000}, // R4
        '{8'd4,  8'h65, 4'h0, 16'h0005, 32'h1,        64'h8000_0000,          64'h0,                  32'd100,        1'b0, 32'd106,  1'b1, 4'b0000}, // R4
        '{8'd4,  8'hd6, 4'h0, 16'h0005, 32'h3,        64'hFFFF_FFFF_0000_0003, 64'h0,                 32'd100,        1'b0, 32'd106,  1'b1, 4'b0000}, // R4
        '{8'd8,  8'h05, 4'h0, 16'h0005, 32'd1000,     64'h0,                  64'h0,                  32'd100,        1'b0, 32'd106,  1'b1, 4'b0000}, // R8
        '{8'd8,  8'h06, 4'h0, 16'h0005, 32'd1000,     64'h0,                  64'h0,                  32'd100,        1'b0, 32'd1101, 1'b1, 4'b0000}, // R8
        '{8'd8,  8'h06, 4'h0, 16'h0005, 32'hFFFF_FFCE, 64'h0,                 64'h0,                  32'd100,        1'b0, 32'd51,   1'b1, 4'b0000}, // R8
        '{8'd9,  8'h85, 4'h0, 16'h0000, 32'd7,        64'h0,                  64'h0,                  32'd100,        1'b0, 32'd101,  1'b0, 4'b1000}, // R9
        '{8'd9,  8'h85, 4'h2, 16'h0000, 32'd7,        64'h0,                  64'h0,                  32'd100,        1'b0, 32'd101,  1'b0, 4'b1000}, // R9
        '{8'd9,  8'h85, 4'h1, 16'h0000, 32'd20,       64'h0,                  64'h0,                  32'd100,        1'b0, 32'd121,  1'b1, 4'b0100}, // R9
        '{8'd10, 8'h95, 4'h0, 16'h0000, 32'h0,        64'h0,                  64'h0,                  32'd100,        1'b0, 32'd101,  1'b0, 4'b0010}, // R10
        '{8'd11, 8'he5, 4'h0, 16'h0005, 32'h0,        64'h0,                  64'h0,                  32'd100,        1'b0, 32'd101,  1'b0, 4'b0001}, // R11
        '{8'd11, 8'hf6, 4'h0, 16'h0005, 32'h0,        64'h0,                  64'h0,                  32'd100,        1'b0, 32'd101,  1'b0, 4'b0001}, // R11
        '{8'd11, 8'h8d, 4'h0, 16'h0000, 32'd7,        64'h0,                  64'h0,                  32'd100,        1'b0, 32'd101,  1'b0, 4'b0001}, // R11
        '{8'd11, 8'h9d, 4'h0, 16'h0000, 32'h0,        64'h0,                  64'h0,                  32'd100,        1'b0, 32'd101,  1'b0, 4'b0001}, // R11
        '{8'd11, 8'h85, 4'h3, 16'h0000, 32'd7,        64'h0,                  64'h0,                  32'd100,        1'b0, 32'd101,  1'b0, 4'b0001}, // R11
        '{8'd7,  8'h1d, 4'h0, 16'h0005, 32'h0,        64'h1,                  64'h2,                  32'd100,        1'b1, 32'd102,  1'b0, 4'b0000}, // R7
        '{8'd7,  8'h5d, 4'h0, 16'h0005, 32'h0,        64'h1,                  64'h2,                  32'd100,        1'b1, 32'd106,  1'b1, 4'b0000}  // R7
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [7:0]       opcode = '0;
    logic [3:0]       sreg_field = '0;
    logic [15:0]      offset = '0;
    logic [31:0]      imm = '0;
    logic [63:0]      dst_val = '0;
    logic [63:0]      src_val = '0;
    logic [IDX_W-1:0] cur_idx = '0;
    logic             wide_insn = 1'b0;
    logic [IDX_W-1:0] next_idx;
    logic             taken;
    logic             helper_call;
    logic             local_call;
    logic             ret;
    logic             illegal;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    branch_resolver #(.IDX_W(IDX_W)) i_branch_resolver (
        .clk         (clk),
        .rst_n       (rst_n),
        .opcode      (opcode),
        .sreg_field  (sreg_field),
        .offset      (offset),
        .imm         (imm),
        .dst_val     (dst_val),
        .src_val     (src_val),
        .cur_idx     (cur_idx),
        .wide_insn   (wide_insn),
        .next_idx    (next_idx),
        .taken       (taken),
        .helper_call (helper_call),
        .local_call  (local_call),
        .ret         (ret),
        .illegal     (illegal)
    );

    task automatic check_out(input int req, input string what,
                             input logic [IDX_W-1:0] e_idx, input logic e_taken,
                             input logic [3:0] e_flags);
        logic [3:0] got;
        got = {helper_call, local_call, ret, illegal};
        checks++;
        if (next_idx !== e_idx || taken !== e_taken || got !== e_flags) begin
            fails++;
            $display("FAIL R%0d %s: got idx=%0d taken=%b flags=%b, expected idx=%0d taken=%b flags=%b",
                     req, what, next_idx, taken, got, e_idx, e_taken, e_flags);
        end
    endtask

    task automatic drive(input vec_t v);
        opcode     = v.opcode;
        sreg_field = v.sreg;
        offset     = v.off;
        imm        = v.imm;
        dst_val    = v.dst;
        src_val    = v.src;
        cur_idx    = v.idx;
        wide_insn  = v.wide;
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        // R1: outputs cleared while reset is held
        drive(VECS[3]);
        repeat (3) @(negedge clk);
        check_out(1, "held in reset", '0, 1'b0, 4'b0000);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i]);
            @(negedge clk);
            check_out(int'(VECS[i].req), $sformatf("vector %0d", i),
                      VECS[i].exp_idx, VECS[i].exp_taken, VECS[i].exp_flags);
        end

        // R2: result holds until the next edge after the inputs change
        @(negedge clk);
        drive(VECS[28]);
        @(negedge clk);
        drive(VECS[0]);
        #1;
        check_out(2, "before edge", 32'd121, 1'b1, 4'b0100);
        @(negedge clk);
        check_out(2, "after edge", 32'd101, 1'b0, 4'b0000);

        // R1: mid-run reset clears a taken result
        drive(VECS[24]);
        @(negedge clk);
        check_out(8, "pre-reset jump", 32'd1101, 1'b1, 4'b0000);
        rst_n = 1'b0;
        #1;
        check_out(1, "async reset", '0, 1'b0, 4'b0000);
        @(negedge clk);
        check_out(1, "reset held over edge", '0, 1'b0, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        check_out(8, "after reset release", 32'd1101, 1'b1, 4'b0000);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule